// File: doc/BRIEF.md
# Snooping Set-Associative Data Cache

This block is the controller and storage of a physically addressed data cache. A core load/store port issues word reads and writes, and each access carries a page attribute that selects copyback, write-through or non-cachable handling. The controller looks up the tag and state arrays, returns hits from its own line storage, and allocates lines on misses. It picks replacement victims and writes dirty victims back before refilling. All external traffic goes through one memory port that moves either a whole line or a single word.

A separate snoop input reports external cycles that are flagged as snoopable. Any line that matches the snooped address is dropped, and the snoop always takes the arrays ahead of the core. A freeze input stops new allocations so that the current contents stay resident, while hits continue to be served.

The core holds `core_req` and its address, data and attributes steady until `core_ack` pulses for one cycle. The memory port uses the same hold-until-acknowledge handshake.

Top module: `snoop_dcache`

## Requirements
- R1: Address fields: the low log2(LINE_BYTES) bits are the line offset, and within the offset bits [offset-1:2] select the 32-bit word. Word w sits at bits [32w+31:32w] of a line. The next log2(NUM_SETS) bits select the set and the remaining upper bits form the tag. A cacheable read miss (attribute 2'b01 or 2'b10) issues one line read at the line-aligned address and returns the addressed word. Later reads of that line make no external transfer, and a line address occupies at most one way.
- R2: After reset `core_ack` and `mem_req` are low. A read hit is acknowledged in the cycle after the request is first seen, and `core_ack` is never high for two cycles in a row.
- R3: A write hit with the copyback attribute (2'b10) updates the cached word and marks the line dirty, with no external transfer.
- R4: A write hit with the write-through attribute (2'b01) updates the cached word and issues one single-word write. The line is not marked dirty, so a later eviction of it makes no write-back.
- R5: A write miss with the write-through attribute issues one single-word write and allocates no line.
- R6: With the non-cachable attribute (2'b00) the access is one single-word transfer. It neither reads nor changes the cache arrays, so a cached copy of the same address keeps its old value.
- R7: The victim is the lowest-numbered invalid way of the set if one exists. Otherwise it is the way given by the set's round-robin pointer, which after every fill points to the way following the one just filled.
- R8: When the victim is dirty, a line write-back of it at its own address is issued first. The line fill starts only after that write-back is acknowledged, and a memory request stays asserted until acknowledged.
- R9: A snoop whose address matches a cached line invalidates that line. Dirty data in it is discarded without a write-back.
- R10: While a snoop is presented, the core access waits. No hit or allocation completes in that cycle, and the access is served once the snoop is gone.
- R11: While freeze is high, a miss allocates nothing and is served as one single-word transfer. Hits are served as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request, held until acknowledged |
| core_we | input | 1 | 1 = write, 0 = read |
| core_mode | input | 2 | Page attribute: 00 non-cachable, 01 write-through, 10 copyback |
| core_addr | input | ADDR_W | Physical byte address (word aligned) |
| core_wdata | input | 32 | Write data |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Read data, valid with core_ack |
| mem_req | output | 1 | External request, held until mem_ack |
| mem_we | output | 1 | 1 = write to memory |
| mem_line | output | 1 | 1 = whole-line transfer, 0 = single word |
| mem_addr | output | ADDR_W | Line-aligned or word address |
| mem_wdata | output | LINE_BYTES*8 | Write data (single word in bits 31:0) |
| mem_ack | input | 1 | One-cycle acknowledge of mem_req |
| mem_rdata | input | LINE_BYTES*8 | Read data, valid with mem_ack (single word in bits 31:0) |
| snp_valid | input | 1 | Snoopable external cycle present |
| snp_addr | input | ADDR_W | Address of the snooped cycle |
| freeze | input | 1 | Stops allocation on misses |

## Verification
The bench builds the cache with a 16-bit address, four sets, two ways and 16-byte lines. With these values, three line addresses spaced 64 bytes apart fall into one set. A handful of accesses is then enough to fill both ways, exercise the invalid-way preference, step the round-robin pointer and force a dirty eviction. The small address space also lets the memory model in the bench hold every word it touches, so write-backs, write-through words and uncached transfers can be compared with precomputed values.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        LN_INV   = 2'b00,
        LN_VAL   = 2'b01,
        LN_DIRTY = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        PG_NOCACHE = 2'b00,
        PG_WTHRU   = 2'b01,
        PG_CBACK   = 2'b10
    } page_mode_t;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_WBACK   = 3'd1,
        S_FILL    = 3'd2,
        S_INSTALL = 3'd3,
        S_SINGLE  = 3'd4
    } ctl_state_t;

endpackage

// File: rtl/dcache_tag_match.sv
module dcache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 19,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0][1:0]       set_state,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    import dcache_pkg::*;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = (set_state[w] != LN_INV) && (set_tags[w] == probe_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/dcache_victim_pick.sv
module dcache_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][1:0] set_state,
    input  logic [WAY_W-1:0]     rr_ptr,
    output logic [WAY_W-1:0]     victim
);
    import dcache_pkg::*;

    always_comb begin
        logic found;
        victim = rr_ptr;
        found  = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!found && set_state[i] == LN_INV) begin
                victim = WAY_W'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/snoop_dcache.sv
module snoop_dcache #(
    parameter int ADDR_W     = 32,
    parameter int NUM_SETS   = 128,
    parameter int NUM_WAYS   = 4,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    core_req,
    input  logic                    core_we,
    input  logic [1:0]              core_mode,
    input  logic [ADDR_W-1:0]       core_addr,
    input  logic [31:0]             core_wdata,
    output logic                    core_ack,
    output logic [31:0]             core_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic                    mem_line,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    input  logic                    mem_ack,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    input  logic                    snp_valid,
    input  logic [ADDR_W-1:0]       snp_addr,
    input  logic                    freeze
);
    import dcache_pkg::*;

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int WSEL_W = OFF_W - 2;

    typedef struct packed {
        ctl_state_t                                      st;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]    tag;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][1:0]          lst;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][LINE_W-1:0]   data;
        logic [NUM_SETS-1:0][WAY_W-1:0]                  rr;
        logic [WAY_W-1:0]                                vway;
        logic                                            mreq;
        logic                                            mwe;
        logic                                            mline;
        logic [ADDR_W-1:0]                               maddr;
        logic [LINE_W-1:0]                               mwdata;
        logic [LINE_W-1:0]                               fbuf;
        logic                                            ack;
        logic [31:0]                                     rdata;
    } regs_t;

    regs_t q, d;

    // Address fields of the core and snoop ports
    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_tag, s_tag;
    logic [WSEL_W-1:0] c_word;
    assign c_idx  = core_addr[OFF_W +: IDX_W];
    assign c_tag  = core_addr[ADDR_W-1 -: TAG_W];
    assign c_word = core_addr[OFF_W-1:2];
    assign s_idx  = snp_addr[OFF_W +: IDX_W];
    assign s_tag  = snp_addr[ADDR_W-1 -: TAG_W];

    logic [NUM_WAYS-1:0] c_hit_vec, s_hit_vec;
    logic                c_hit, s_hit;
    logic [WAY_W-1:0]    c_way, s_way, vic;

    dcache_tag_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_core_match (
        .set_tags (q.tag[c_idx]),
        .set_state(q.lst[c_idx]),
        .probe_tag(c_tag),
        .hit_vec  (c_hit_vec),
        .hit      (c_hit),
        .hit_way  (c_way)
    );

    dcache_tag_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_snoop_match (
        .set_tags (q.tag[s_idx]),
        .set_state(q.lst[s_idx]),
        .probe_tag(s_tag),
        .hit_vec  (s_hit_vec),
        .hit      (s_hit),
        .hit_way  (s_way)
    );

    dcache_victim_pick #(.WAYS(NUM_WAYS)) u_victim (
        .set_state(q.lst[c_idx]),
        .rr_ptr   (q.rr[c_idx]),
        .victim   (vic)
    );

    logic cacheable;
    assign cacheable = (core_mode == PG_WTHRU) || (core_mode == PG_CBACK);

    always_comb begin
        d     = q;
        d.ack = 1'b0;

        // Snoop owns the state array whenever it is presented
        if (snp_valid && s_hit) d.lst[s_idx][s_way] = LN_INV;

        case (q.st)
            S_IDLE: begin
                if (!snp_valid && core_req && !q.ack) begin
                    if (!cacheable || (!c_hit && (freeze || (core_we && core_mode == PG_WTHRU)))) begin
                        d.mreq   = 1'b1;
                        d.mwe    = core_we;
                        d.mline  = 1'b0;
                        d.maddr  = {core_addr[ADDR_W-1:2], 2'b00};
                        d.mwdata = {{(LINE_W-32){1'b0}}, core_wdata};
                        d.st     = S_SINGLE;
                    end else if (c_hit) begin
                        if (!core_we) begin
                            d.ack   = 1'b1;
                            d.rdata = q.data[c_idx][c_way][{c_word, 5'd0} +: 32];
                        end else begin
                            d.data[c_idx][c_way][{c_word, 5'd0} +: 32] = core_wdata;
                            if (core_mode == PG_CBACK) begin
                                d.lst[c_idx][c_way] = LN_DIRTY;
                                d.ack = 1'b1;
                            end else begin
                                d.mreq   = 1'b1;
                                d.mwe    = 1'b1;
                                d.mline  = 1'b0;
                                d.maddr  = {core_addr[ADDR_W-1:2], 2'b00};
                                d.mwdata = {{(LINE_W-32){1'b0}}, core_wdata};
                                d.st     = S_SINGLE;
                            end
                        end
                    end else begin
                        d.vway  = vic;
                        d.mreq  = 1'b1;
                        d.mline = 1'b1;
                        if (q.lst[c_idx][vic] == LN_DIRTY) begin
                            d.mwe    = 1'b1;
                            d.maddr  = {q.tag[c_idx][vic], c_idx, {OFF_W{1'b0}}};
                            d.mwdata = q.data[c_idx][vic];
                            d.st     = S_WBACK;
                        end else begin
                            d.mwe   = 1'b0;
                            d.maddr = {c_tag, c_idx, {OFF_W{1'b0}}};
                            d.st    = S_FILL;
                        end
                    end
                end
            end
            S_WBACK: begin
                if (mem_ack) begin
                    d.mwe   = 1'b0;
                    d.maddr = {c_tag, c_idx, {OFF_W{1'b0}}};
                    d.st    = S_FILL;
                end
            end
            S_FILL: begin
                if (mem_ack) begin
                    d.fbuf = mem_rdata;
                    d.mreq = 1'b0;
                    d.st   = S_INSTALL;
                end
            end
            S_INSTALL: begin
                if (!snp_valid) begin
                    d.data[c_idx][q.vway] = q.fbuf;
                    d.tag[c_idx][q.vway]  = c_tag;
                    d.lst[c_idx][q.vway]  = LN_VAL;
                    d.rr[c_idx]           = q.vway + WAY_W'(1);
                    d.st                  = S_IDLE;
                end
            end
            S_SINGLE: begin
                if (mem_ack) begin
                    d.mreq  = 1'b0;
                    d.ack   = 1'b1;
                    d.rdata = mem_rdata[31:0];
                    d.st    = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.lst   <= '0;
            q.rr    <= '0;
            q.vway  <= '0;
            q.mreq  <= 1'b0;
            q.mwe   <= 1'b0;
            q.mline <= 1'b0;
            q.maddr <= '0;
            q.ack   <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign core_ack   = q.ack;
    assign core_rdata = q.rdata;
    assign mem_req    = q.mreq;
    assign mem_we     = q.mwe;
    assign mem_line   = q.mline;
    assign mem_addr   = q.maddr;
    assign mem_wdata  = q.mwdata;
endmodule

// File: rtl/snoop_dcache_chk.sv
module snoop_dcache_chk #(
    parameter int WAYS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            core_req,
    input logic [1:0]      core_mode,
    input logic            core_ack,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_line,
    input logic            mem_ack,
    input logic            snp_valid,
    input logic            freeze,
    input logic [WAYS-1:0] hit_vec
);
    // R1
    single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !core_ack);

    // R6
    nocache_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && $past(core_req && core_mode == 2'b00)) |-> !mem_line);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R8
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_line && mem_ack) |=> (mem_req && !mem_we && mem_line));

    // R10
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !mem_req) |=> !core_ack);

    // R11
    freeze_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && $past(freeze)) |-> !mem_line);
endmodule

bind snoop_dcache snoop_dcache_chk #(.WAYS(NUM_WAYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_req (core_req),
    .core_mode(core_mode),
    .core_ack (core_ack),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_line (mem_line),
    .mem_ack  (mem_ack),
    .snp_valid(snp_valid),
    .freeze   (freeze),
    .hit_vec  (c_hit_vec)
);

// File: tb/snoop_dcache_bench.sv
`timescale 1ns/1ps
module snoop_dcache_bench;
    localparam int AW = 16;
    localparam int LB = 16;
    localparam int LW = LB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0;
    logic          core_we = 1'b0;
    logic [1:0]    core_mode = 2'b00;
    logic [AW-1:0] core_addr = '0;
    logic [31:0]   core_wdata = '0;
    logic          core_ack;
    logic [31:0]   core_rdata;
    logic          mem_req, mem_we, mem_line;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [LW-1:0] mem_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          freeze = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    snoop_dcache #(.ADDR_W(AW), .NUM_SETS(4), .NUM_WAYS(2), .LINE_BYTES(LB)) u_snoop_dcache (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_mode(core_mode),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ack(core_ack), .core_rdata(core_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .freeze(freeze)
    );

    // Memory model: 1024 words, fixed three-cycle answer
    logic [31:0] mem [0:1023];
    int n_lrd = 0, n_lwr = 0, n_wrd = 0, n_wwr = 0;
    logic [AW-1:0] last_wb_addr = '0;
    logic [AW-1:0] last_fill_addr = '0;
    int wait_cnt = 0;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 + i;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 2) begin
                wait_cnt <= 0;
                mem_ack  <= 1'b1;
                if (mem_line) begin
                    if (mem_we) begin
                        for (int w = 0; w < 4; w++) mem[{mem_addr[11:4], 2'b00} + w] <= mem_wdata[w*32 +: 32];
                        n_lwr <= n_lwr + 1;
                        last_wb_addr <= mem_addr;
                    end else begin
                        for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] <= mem[{mem_addr[11:4], 2'b00} + w];
                        n_lrd <= n_lrd + 1;
                        last_fill_addr <= mem_addr;
                    end
                end else if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata[31:0];
                    n_wwr <= n_wwr + 1;
                end else begin
                    mem_rdata <= {{(LW-32){1'b0}}, mem[mem_addr[11:2]]};
                    n_wrd <= n_wrd + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] mode, input logic [AW-1:0] addr,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_mode = mode; core_addr = addr; core_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!core_ack);
        rd = core_rdata;
        core_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 reset core_ack", 32'(core_ack), 0);
        chk("R2 reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_read_fill_hit();
        logic [31:0] rd; int cyc; int l0;
        l0 = n_lrd;
        acc(0, 2'b10, 16'h0104, 0, rd, cyc);
        chk("R1 miss data", rd, 32'hA000_0041);
        chk("R1 one fill", n_lrd - l0, 1);
        chk("R1 fill line address", 32'(last_fill_addr), 32'h0100);
        l0 = n_lrd;
        acc(0, 2'b10, 16'h0108, 0, rd, cyc);
        chk("R1 hit data", rd, 32'hA000_0042);
        chk("R1 hit no traffic", n_lrd - l0, 0);
        chk("R2 hit latency", cyc, 1);
    endtask

    task automatic t_copyback_write();
        logic [31:0] rd; int cyc; int w0, l0;
        w0 = n_wwr; l0 = n_lwr;
        acc(1, 2'b10, 16'h0104, 32'h1111_1111, rd, cyc);
        chk("R3 no word write", n_wwr - w0, 0);
        chk("R3 no line write", n_lwr - l0, 0);
        chk("R3 memory untouched", mem[16'h0104 >> 2], 32'hA000_0041);
        acc(0, 2'b10, 16'h0104, 0, rd, cyc);
        chk("R3 updated word", rd, 32'h1111_1111);
    endtask

    task automatic t_replace_evict();
        logic [31:0] rd; int cyc; int l0, w0;
        l0 = n_lrd; w0 = n_lwr;
        acc(0, 2'b10, 16'h0140, 0, rd, cyc);
        chk("R7 invalid way used, no write-back", n_lwr - w0, 0);
        l0 = n_lrd;
        acc(0, 2'b10, 16'h0100, 0, rd, cyc);
        chk("R7 first line kept", n_lrd - l0, 0);
        l0 = n_lrd; w0 = n_lwr;
        acc(0, 2'b10, 16'h0184, 0, rd, cyc);
        chk("R8 dirty victim written back", n_lwr - w0, 1);
        chk("R8 write-back address", 32'(last_wb_addr), 32'h0100);
        chk("R8 write-back data", mem[16'h0104 >> 2], 32'h1111_1111);
        chk("R8 fill after write-back", n_lrd - l0, 1);
        chk("R8 fill data", rd, 32'hA000_0061);
        l0 = n_lrd;
        acc(0, 2'b10, 16'h0140, 0, rd, cyc);
        chk("R7 round-robin spared way 1", n_lrd - l0, 0);
        l0 = n_lrd; w0 = n_lwr;
        acc(0, 2'b10, 16'h0104, 0, rd, cyc);
        chk("R7 refill after eviction", n_lrd - l0, 1);
        chk("R7 clean victim not written", n_lwr - w0, 0);
        chk("R7 refilled data", rd, 32'h1111_1111);
    endtask

    task automatic t_write_through();
        logic [31:0] rd; int cyc; int l0, w0, lw0;
        w0 = n_wwr; l0 = n_lrd;
        acc(1, 2'b01, 16'h0184, 32'h2222_2222, rd, cyc);
        chk("R4 word write issued", n_wwr - w0, 1);
        chk("R4 memory updated", mem[16'h0184 >> 2], 32'h2222_2222);
        acc(0, 2'b10, 16'h0184, 0, rd, cyc);
        chk("R4 cached word updated", rd, 32'h2222_2222);
        chk("R4 hit no fill", n_lrd - l0, 0);
        w0 = n_wwr; l0 = n_lrd; lw0 = n_lwr;
        acc(1, 2'b01, 16'h0204, 32'h3333_3333, rd, cyc);
        chk("R5 word write issued", n_wwr - w0, 1);
        chk("R5 no fill", n_lrd - l0, 0);
        chk("R5 memory updated", mem[16'h0204 >> 2], 32'h3333_3333);
        acc(0, 2'b10, 16'h0204, 0, rd, cyc);
        chk("R5 not allocated", n_lrd - l0, 1);
        chk("R5 read data", rd, 32'h3333_3333);
        chk("R4 line not dirty after write-through", n_lwr - lw0, 0);
    endtask

    task automatic t_nocache();
        logic [31:0] rd; int cyc; int l0, w0, r0;
        w0 = n_wwr; l0 = n_lrd;
        acc(1, 2'b00, 16'h0208, 32'h4444_4444, rd, cyc);
        chk("R6 word write", n_wwr - w0, 1);
        chk("R6 memory updated", mem[16'h0208 >> 2], 32'h4444_4444);
        acc(0, 2'b10, 16'h0208, 0, rd, cyc);
        chk("R6 cached copy unchanged", rd, 32'hA000_0082);
        chk("R6 still a hit", n_lrd - l0, 0);
        r0 = n_wrd;
        acc(0, 2'b00, 16'h0300, 0, rd, cyc);
        chk("R6 word read", n_wrd - r0, 1);
        chk("R6 no line read", n_lrd - l0, 0);
        chk("R6 read data", rd, 32'hA000_00C0);
    endtask

    task automatic t_freeze();
        logic [31:0] rd; int cyc; int l0, w0, r0, lw0;
        freeze = 1'b1;
        l0 = n_lrd; r0 = n_wrd;
        acc(0, 2'b10, 16'h0340, 0, rd, cyc);
        chk("R11 miss as word read", n_wrd - r0, 1);
        chk("R11 no fill", n_lrd - l0, 0);
        chk("R11 miss data", rd, 32'hA000_00D0);
        r0 = n_wrd;
        acc(0, 2'b10, 16'h0208, 0, rd, cyc);
        chk("R11 hit served", rd, 32'hA000_0082);
        chk("R11 hit no traffic", n_wrd - r0, 0);
        chk("R11 hit latency", cyc, 1);
        w0 = n_wwr;
        acc(1, 2'b10, 16'h0344, 32'h5555_5555, rd, cyc);
        chk("R11 write miss as word write", n_wwr - w0, 1);
        chk("R11 write miss memory", mem[16'h0344 >> 2], 32'h5555_5555);
        freeze = 1'b0;
        l0 = n_lrd; lw0 = n_lwr;
        acc(0, 2'b10, 16'h0340, 0, rd, cyc);
        chk("R11 earlier miss not allocated", n_lrd - l0, 1);
        chk("R11 clean victim", n_lwr - lw0, 0);
    endtask

    task automatic t_snoop();
        logic [31:0] rd; int cyc; int l0, lw0;
        acc(1, 2'b10, 16'h0204, 32'h6666_6666, rd, cyc);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = 16'h0200;
        @(negedge clk);
        snp_valid = 1'b0;
        l0 = n_lrd; lw0 = n_lwr;
        acc(0, 2'b10, 16'h0204, 0, rd, cyc);
        chk("R9 line invalidated", n_lrd - l0, 1);
        chk("R9 dirty data not written back", n_lwr - lw0, 0);
        chk("R9 memory value returned", rd, 32'h3333_3333);
    endtask

    task automatic t_snoop_priority();
        @(negedge clk);
        core_req = 1'b1; core_we = 1'b0; core_mode = 2'b10; core_addr = 16'h0204;
        snp_valid = 1'b1; snp_addr = 16'h0500;
        @(negedge clk);
        chk("R10 core stalled cycle 1", 32'(core_ack), 0);
        @(negedge clk);
        chk("R10 core stalled cycle 2", 32'(core_ack), 0);
        snp_valid = 1'b0;
        @(negedge clk);
        chk("R10 served after snoop", 32'(core_ack), 1);
        chk("R10 data after snoop", core_rdata, 32'h3333_3333);
        core_req = 1'b0;
        @(negedge clk);
        chk("R2 single-cycle ack", 32'(core_ack), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read_fill_hit();
        t_copyback_write();
        t_replace_evict();
        t_write_through();
        t_nocache();
        t_freeze();
        t_snoop();
        t_snoop_priority();
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule